// File: doc/BRIEF.md
# Clock-Recovery Acquisition Mode Controller

This block is the digital supervisor that sits beside an abstracted clock-and-data-recovery loop. It holds a small mode register, watches three status inputs from the loop (a lock-achieved indication, a loss-of-signal detect and a rate-change detect), and decides when a new frequency acquisition begins and whether the recovered clock is frozen in holdover. It reports loss-of-lock, drives a loss-of-signal pin of programmable polarity, tells the loop which subharmonic ratio to acquire on, and enables or disables two output buffer groups.

Recovered data passes through the block as a valid/ready stream with no storage. The sink's `out_ready` is handed straight back as `in_ready`, and `in_valid` straight forward as `out_valid`, in the same cycle. Back-pressure is therefore never absorbed or buffered: a beat moves only in a cycle where both valid and ready are high at the source. When subharmonic lock is enabled, beats still flow, but their payload reads zero until lock is reached. A bypass setting passes the payload through untouched. A 9-bit coarse rate readback word is assembled from the stored rate code and a status bit from the loop.

Top module: `cdr_acq_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after, `lol` is 1, `holdover` and `acq_start` are 0, and every mode bit is cleared. This means no hold mode, no subharmonic mode, no bypass, `los_pin` active high, and both buffer enables at 1. In the first cycle after `rst_n` rises, with `sw_reset` low, acquisition begins.
- R2: While `sw_reset` is 1, the controller sits in its reset state: `lol` is 1 and `acq_start` is 0. Acquisition begins only in the cycle after `sw_reset` returns to 0. The stored mode bits are unchanged by this sequence.
- R3: `acq_start` is high for exactly one cycle, the first cycle of each acquisition, and `lol` is 1 in that cycle. A rate change seen during acquisition does not raise a second pulse.
- R4: When `st_lock` is 1 during acquisition, `lol` goes to 0 in the next cycle. At the same time, `holdover` goes to 1 if either hold mode is set, or stays 0 otherwise.
- R5: With no hold mode set, a locked controller that sees `st_los` or `st_rate_change` starts a new acquisition.
- R6: In hold mode A, a controller in holdover ignores `st_los` and `st_rate_change`; only a software reset starts a new acquisition. Mode A takes priority when both hold modes are set.
- R7: In hold mode B, a controller in holdover ignores `st_los`, but `st_rate_change` starts a new acquisition.
- R8: With subharmonic mode set and bypass clear, `out_data` is all zeros whenever `lol` is 1. Otherwise it equals `in_data`.
- R9: `acq_ratio` equals the stored 5-bit ratio field when subharmonic mode is set, with a stored 0 read as 1. It is 1 when subharmonic mode is clear.
- R10: `los_pin` equals `st_los` when the stored polarity bit is 0, and `~st_los` when it is 1.
- R11: While `lol` is 0, `rb_valid` is 1 and `rb_word` is {stored rate code, `st_rate_lsb`}, with the status bit at bit 0. While `lol` is 1, `rb_valid` is 0 and `rb_word` is 0.
- R12: With bypass set, `out_data` equals `in_data` regardless of squelch. `buf_a_en` and `buf_b_en` are the inverses of their stored disable bits.
- R13: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle.
- R14: A cycle with `cfg_we` high loads every `cfg_*` field into the mode register. The new values govern outputs and transitions from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load all cfg_* fields into the mode register |
| cfg_hold_a | input | 1 | Hold mode A (software-only restart) |
| cfg_hold_b | input | 1 | Hold mode B (restart on rate change) |
| cfg_subh_en | input | 1 | Subharmonic lock mode |
| cfg_subh_ratio | input | RATIO_W | Subharmonic ratio |
| cfg_los_inv | input | 1 | 1 makes los_pin active low |
| cfg_bypass | input | 1 | Pass data around recovery and squelch |
| cfg_buf_a_off | input | 1 | Disable output buffer group A |
| cfg_buf_b_off | input | 1 | Disable output buffer group B |
| cfg_rate_code | input | RATE_W | Rate code stored for readback |
| sw_reset | input | 1 | Software reset control bit |
| st_lock | input | 1 | Loop reports lock achieved |
| st_los | input | 1 | Loss-of-signal detect |
| st_rate_change | input | 1 | Input rate change detect |
| st_rate_lsb | input | 1 | Status bit placed at readback bit 0 |
| in_valid | input | 1 | Recovered data beat valid |
| in_data | input | DATA_W | Recovered data payload |
| in_ready | output | 1 | Ready back to the data source |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output payload |
| out_ready | input | 1 | Sink ready |
| lol | output | 1 | Loss of lock |
| holdover | output | 1 | Recovered frequency frozen |
| acq_start | output | 1 | One-cycle acquisition start strobe |
| acq_ratio | output | RATIO_W | Ratio the loop acquires on |
| los_pin | output | 1 | Loss-of-signal pin, programmable polarity |
| rb_word | output | RATE_W+1 | Coarse rate readback word |
| rb_valid | output | 1 | Readback word valid |
| buf_a_en | output | 1 | Buffer group A enable |
| buf_b_en | output | 1 | Buffer group B enable |

## Verification
The bench builds the block with its defaults: 8-bit data, an 8-bit rate code and a 5-bit ratio field. With these settings, the ratio extremes 0, 5 and 31 and every readback bit can be driven directly. A behavioural model tracks the controller's state and stored modes, and is compared on every cycle as the bench walks through each hold mode, both at once, software reset, squelch with and without bypass, polarity inversion and buffer disables. Throughout the run, valid and ready toggle on their own patterns.

// File: rtl/cdr_acq_pkg.sv
package cdr_acq_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_ACQ   = 2'd1,
    ST_LOCK  = 2'd2,
    ST_HOLD  = 2'd3
  } acq_state_e;

  function automatic logic state_unlocked(acq_state_e s);
    return (s == ST_RESET) || (s == ST_ACQ);
  endfunction

endpackage

// File: rtl/cdr_mode_regs.sv
module cdr_mode_regs #(
  parameter int RATE_W  = 8,
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               hold_a_d,
  input  logic               hold_b_d,
  input  logic               subh_en_d,
  input  logic [RATIO_W-1:0] subh_ratio_d,
  input  logic               los_inv_d,
  input  logic               bypass_d,
  input  logic               buf_a_off_d,
  input  logic               buf_b_off_d,
  input  logic [RATE_W-1:0]  rate_code_d,
  output logic               hold_a_q,
  output logic               hold_b_q,
  output logic               subh_en_q,
  output logic [RATIO_W-1:0] subh_ratio_q,
  output logic               los_inv_q,
  output logic               bypass_q,
  output logic               buf_a_off_q,
  output logic               buf_b_off_q,
  output logic [RATE_W-1:0]  rate_code_q
);

  localparam int FLAG_N = 7;

  logic [FLAG_N-1:0] flags_d, flags_q;

  assign flags_d = {hold_a_d, hold_b_d, subh_en_d, los_inv_d,
                    bypass_d, buf_a_off_d, buf_b_off_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q      <= '0;
      subh_ratio_q <= '0;
      rate_code_q  <= '0;
    end else if (we) begin
      flags_q      <= flags_d;
      subh_ratio_q <= subh_ratio_d;
      rate_code_q  <= rate_code_d;
    end
  end

  assign {hold_a_q, hold_b_q, subh_en_q, los_inv_q,
          bypass_q, buf_a_off_q, buf_b_off_q} = flags_q;

endmodule

// File: rtl/cdr_acq_fsm.sv
module cdr_acq_fsm
  import cdr_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_reset,
  input  logic       hold_a,
  input  logic       hold_b,
  input  logic       st_lock,
  input  logic       st_los,
  input  logic       st_rate_change,
  output acq_state_e state,
  output logic       acq_start
);

  acq_state_e state_d;
  logic       hold_any;
  logic       lock_disturb;

  assign hold_any     = hold_a | hold_b;
  assign lock_disturb = st_los | st_rate_change;

  always_comb begin
    state_d = state;
    if (sw_reset) begin
      state_d = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET: state_d = ST_ACQ;
        ST_ACQ: begin
          if (st_lock) state_d = hold_any ? ST_HOLD : ST_LOCK;
        end
        ST_LOCK: begin
          if (lock_disturb)  state_d = ST_ACQ;
          else if (hold_any) state_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (hold_a)            state_d = ST_HOLD;
          else if (hold_b)       state_d = st_rate_change ? ST_ACQ : ST_HOLD;
          else if (lock_disturb) state_d = ST_ACQ;
          else                   state_d = ST_LOCK;
        end
        default: state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RESET;
      acq_start <= 1'b0;
    end else begin
      state     <= state_d;
      acq_start <= (state_d == ST_ACQ) && (state != ST_ACQ);
    end
  end

endmodule

// File: rtl/cdr_out_path.sv
module cdr_out_path #(
  parameter int DATA_W  = 8,
  parameter int RATE_W  = 8,
  parameter int RATIO_W = 5
) (
  input  logic               unlocked,
  input  logic               subh_en,
  input  logic [RATIO_W-1:0] subh_ratio,
  input  logic               bypass,
  input  logic               los_inv,
  input  logic               buf_a_off,
  input  logic               buf_b_off,
  input  logic [RATE_W-1:0]  rate_code,
  input  logic               st_los,
  input  logic               st_rate_lsb,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  input  logic               out_ready,
  output logic [RATIO_W-1:0] acq_ratio,
  output logic               los_pin,
  output logic [RATE_W:0]    rb_word,
  output logic               rb_valid,
  output logic               buf_a_en,
  output logic               buf_b_en
);

  localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);

  logic squelch;

  assign squelch   = subh_en & unlocked & ~bypass;
  assign out_data  = squelch ? '0 : in_data;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  always_comb begin
    if (!subh_en || subh_ratio == '0) acq_ratio = RATIO_ONE;
    else                              acq_ratio = subh_ratio;
  end

  assign los_pin  = los_inv ? ~st_los : st_los;
  assign rb_valid = ~unlocked;
  assign rb_word  = unlocked ? '0 : {rate_code, st_rate_lsb};
  assign buf_a_en = ~buf_a_off;
  assign buf_b_en = ~buf_b_off;

endmodule

// File: rtl/cdr_acq_ctrl.sv
module cdr_acq_ctrl
  import cdr_acq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RATE_W  = 8,
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_hold_a,
  input  logic               cfg_hold_b,
  input  logic               cfg_subh_en,
  input  logic [RATIO_W-1:0] cfg_subh_ratio,
  input  logic               cfg_los_inv,
  input  logic               cfg_bypass,
  input  logic               cfg_buf_a_off,
  input  logic               cfg_buf_b_off,
  input  logic [RATE_W-1:0]  cfg_rate_code,
  input  logic               sw_reset,
  input  logic               st_lock,
  input  logic               st_los,
  input  logic               st_rate_change,
  input  logic               st_rate_lsb,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  input  logic               out_ready,
  output logic               lol,
  output logic               holdover,
  output logic               acq_start,
  output logic [RATIO_W-1:0] acq_ratio,
  output logic               los_pin,
  output logic [RATE_W:0]    rb_word,
  output logic               rb_valid,
  output logic               buf_a_en,
  output logic               buf_b_en
);

  logic               hold_a_q, hold_b_q, subh_en_q, los_inv_q;
  logic               bypass_q, buf_a_off_q, buf_b_off_q;
  logic [RATIO_W-1:0] subh_ratio_q;
  logic [RATE_W-1:0]  rate_code_q;
  acq_state_e         state;

  cdr_mode_regs #(.RATE_W(RATE_W), .RATIO_W(RATIO_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (cfg_we),
    .hold_a_d     (cfg_hold_a),
    .hold_b_d     (cfg_hold_b),
    .subh_en_d    (cfg_subh_en),
    .subh_ratio_d (cfg_subh_ratio),
    .los_inv_d    (cfg_los_inv),
    .bypass_d     (cfg_bypass),
    .buf_a_off_d  (cfg_buf_a_off),
    .buf_b_off_d  (cfg_buf_b_off),
    .rate_code_d  (cfg_rate_code),
    .hold_a_q     (hold_a_q),
    .hold_b_q     (hold_b_q),
    .subh_en_q    (subh_en_q),
    .subh_ratio_q (subh_ratio_q),
    .los_inv_q    (los_inv_q),
    .bypass_q     (bypass_q),
    .buf_a_off_q  (buf_a_off_q),
    .buf_b_off_q  (buf_b_off_q),
    .rate_code_q  (rate_code_q)
  );

  cdr_acq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_reset       (sw_reset),
    .hold_a         (hold_a_q),
    .hold_b         (hold_b_q),
    .st_lock        (st_lock),
    .st_los         (st_los),
    .st_rate_change (st_rate_change),
    .state          (state),
    .acq_start      (acq_start)
  );

  assign lol      = state_unlocked(state);
  assign holdover = (state == ST_HOLD);

  cdr_out_path #(.DATA_W(DATA_W), .RATE_W(RATE_W), .RATIO_W(RATIO_W)) u_out (
    .unlocked    (lol),
    .subh_en     (subh_en_q),
    .subh_ratio  (subh_ratio_q),
    .bypass      (bypass_q),
    .los_inv     (los_inv_q),
    .buf_a_off   (buf_a_off_q),
    .buf_b_off   (buf_b_off_q),
    .rate_code   (rate_code_q),
    .st_los      (st_los),
    .st_rate_lsb (st_rate_lsb),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .acq_ratio   (acq_ratio),
    .los_pin     (los_pin),
    .rb_word     (rb_word),
    .rb_valid    (rb_valid),
    .buf_a_en    (buf_a_en),
    .buf_b_en    (buf_b_en)
  );

endmodule

// File: rtl/cdr_acq_ctrl_chk.sv
module cdr_acq_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_reset,
  input logic              st_rate_change,
  input logic              lol,
  input logic              holdover,
  input logic              acq_start,
  input logic              hold_a,
  input logic              hold_b,
  input logic              subh_en,
  input logic              bypass,
  input logic [DATA_W-1:0] out_data,
  input logic [RATE_W:0]   rb_word,
  input logic              rb_valid
);

  assert_acq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> !acq_start);

  assert_acq_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |-> lol);

  assert_swrst_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (lol && !acq_start));

  assert_hold_a_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && hold_a && !sw_reset) |=> holdover);

  assert_hold_b_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && !hold_a && hold_b && st_rate_change && !sw_reset) |=> acq_start);

  assert_squelch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (subh_en && !bypass && lol) |-> (out_data == '0));

  assert_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lol |-> (!rb_valid && rb_word == '0));

endmodule

bind cdr_acq_ctrl cdr_acq_ctrl_chk #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sw_reset       (sw_reset),
  .st_rate_change (st_rate_change),
  .lol            (lol),
  .holdover       (holdover),
  .acq_start      (acq_start),
  .hold_a         (hold_a_q),
  .hold_b         (hold_b_q),
  .subh_en        (subh_en_q),
  .bypass         (bypass_q),
  .out_data       (out_data),
  .rb_word        (rb_word),
  .rb_valid       (rb_valid)
);

// File: tb/tb_cdr_acq_ctrl.sv
`timescale 1ns/1ps
module tb_cdr_acq_ctrl;

  localparam int DATA_W  = 8;
  localparam int RATE_W  = 8;
  localparam int RATIO_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_hold_a = 0, cfg_hold_b = 0, cfg_subh_en = 0;
  logic [RATIO_W-1:0] cfg_subh_ratio = '0;
  logic cfg_los_inv = 0, cfg_bypass = 0, cfg_buf_a_off = 0, cfg_buf_b_off = 0;
  logic [RATE_W-1:0] cfg_rate_code = '0;
  logic sw_reset = 0, st_lock = 0, st_los = 0, st_rate_change = 0, st_rate_lsb = 0;
  logic in_valid = 0, out_ready = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, lol, holdover, acq_start, los_pin, rb_valid, buf_a_en, buf_b_en;
  logic [DATA_W-1:0] out_data;
  logic [RATIO_W-1:0] acq_ratio;
  logic [RATE_W:0] rb_word;

  always #2 clk = ~clk;

  cdr_acq_ctrl #(.DATA_W(DATA_W), .RATE_W(RATE_W), .RATIO_W(RATIO_W)) dut (.*);

  int errors = 0;
  int checks = 0;
  string phase = "R1";
  bit done = 0;

  // reference model: state 0 reset, 1 acquire, 2 locked, 3 holdover
  int m_st = 0;
  bit m_acq = 0;
  bit m_hold_a, m_hold_b, m_subh, m_inv, m_byp, m_boa, m_bob;
  int m_ratio, m_rate;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_acq = 0;
      m_hold_a = 0; m_hold_b = 0; m_subh = 0; m_inv = 0; m_byp = 0;
      m_boa = 0; m_bob = 0; m_ratio = 0; m_rate = 0;
    end else begin
      int nx;
      bit hany;
      hany = m_hold_a || m_hold_b;
      nx = m_st;
      if (sw_reset) nx = 0;
      else if (m_st == 0) nx = 1;
      else if (m_st == 1) begin
        if (st_lock) nx = hany ? 3 : 2;
      end else if (m_st == 2) begin
        if (st_los || st_rate_change) nx = 1;
        else if (hany) nx = 3;
      end else begin
        if (m_hold_a) nx = 3;
        else if (m_hold_b) nx = st_rate_change ? 1 : 3;
        else nx = (st_los || st_rate_change) ? 1 : 2;
      end
      m_acq = (nx == 1) && (m_st != 1);
      m_st = nx;
      if (cfg_we) begin
        m_hold_a = cfg_hold_a; m_hold_b = cfg_hold_b; m_subh = cfg_subh_en;
        m_inv = cfg_los_inv; m_byp = cfg_bypass; m_boa = cfg_buf_a_off;
        m_bob = cfg_buf_b_off; m_ratio = cfg_subh_ratio; m_rate = cfg_rate_code;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit mlol;
    longint ed, er;
    mlol = (m_st <= 1);
    chk(phase, "lol", lol, mlol);
    chk(phase, "holdover", holdover, m_st == 3);
    chk(phase, "acq_start", acq_start, m_acq);
    ed = (!m_byp && m_subh && mlol) ? 0 : in_data;
    chk("R8/R12", "out_data", out_data, ed);
    chk("R9", "acq_ratio", acq_ratio, m_subh ? ((m_ratio == 0) ? 1 : m_ratio) : 1);
    chk("R10", "los_pin", los_pin, st_los ^ m_inv);
    er = mlol ? 0 : ((m_rate << 1) | st_rate_lsb);
    chk("R11", "rb_word", rb_word, er);
    chk("R11", "rb_valid", rb_valid, !mlol);
    chk("R12", "buf_en", {buf_a_en, buf_b_en}, {!m_boa, !m_bob});
    chk("R13", "stream", {out_valid, in_ready}, {in_valid, out_ready});
  end

  // free-running stream pattern
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    in_data   <= DATA_W'(cyc * 37 + 11);
    in_valid  <= (cyc % 3) != 0;
    out_ready <= (cyc % 5) != 1;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(bit ha, bit hb, bit se, int ratio, bit inv, bit byp,
                     bit boa, bit bob, int rate);
    cfg_hold_a = ha; cfg_hold_b = hb; cfg_subh_en = se;
    cfg_subh_ratio = RATIO_W'(ratio); cfg_los_inv = inv; cfg_bypass = byp;
    cfg_buf_a_off = boa; cfg_buf_b_off = bob; cfg_rate_code = RATE_W'(rate);
    cfg_we = 1; step(1); cfg_we = 0;
  endtask

  task automatic pulse_lock;
    st_lock = 1; step(1); st_lock = 0; step(1);
  endtask

  task automatic sw_rst(int n);
    sw_reset = 1; step(n); sw_reset = 0; step(1);
  endtask

  initial begin
    phase = "R1";
    cfg_we = 1; cfg_hold_a = 1; cfg_bypass = 1; // ignored during reset (R1)
    step(3);
    cfg_we = 0; cfg_hold_a = 0; cfg_bypass = 0;
    #1;
    chk("R1", "lol in reset", lol, 1);
    chk("R1", "acq_start in reset", acq_start, 0);
    rst_n = 1;
    step(1);
    chk("R1", "acq pulse after reset", acq_start, 1);
    step(2);
    phase = "R4"; st_lock = 1; step(1); st_lock = 0;
    chk("R4", "locked lol", lol, 0);
    phase = "R5"; st_rate_change = 1; step(1); st_rate_change = 0;
    chk("R5", "restart on rate change", acq_start, 1);
    phase = "R3"; st_rate_change = 1; step(2); st_rate_change = 0;
    chk("R3", "no second pulse", acq_start, 0);
    pulse_lock();
    phase = "R5"; st_los = 1; step(1); st_los = 0; step(1); pulse_lock();
    phase = "R14"; st_rate_lsb = 1;
    cfg(1, 0, 0, 0, 0, 0, 0, 0, 8'hA5);
    step(1);
    chk("R14", "holdover from config", holdover, 1);
    phase = "R6"; st_los = 1; st_rate_change = 1; step(4);
    st_los = 0; st_rate_change = 0;
    chk("R6", "mode A holds", holdover, 1);
    phase = "R2"; sw_reset = 1; step(3);
    chk("R2", "lol during sw reset", lol, 1);
    sw_reset = 0; step(1);
    chk("R2", "restart after fall", acq_start, 1);
    pulse_lock();
    chk("R2", "mode kept", holdover, 1);
    phase = "R7"; cfg(0, 1, 0, 0, 0, 0, 0, 0, 8'h3C);
    st_los = 1; step(3); st_los = 0;
    chk("R7", "los ignored", holdover, 1);
    st_rate_change = 1; step(1); st_rate_change = 0;
    chk("R7", "rate restart", acq_start, 1);
    pulse_lock();
    phase = "R6"; cfg(1, 1, 0, 0, 0, 0, 0, 0, 8'h3C);
    st_rate_change = 1; step(3); st_rate_change = 0;
    chk("R6", "A over B", holdover, 1);
    phase = "R8"; cfg(0, 0, 1, 5, 0, 0, 0, 0, 8'h81);
    sw_rst(2); step(3);
    chk("R8", "squelch", out_data, 0);
    pulse_lock(); step(2);
    phase = "R9"; cfg(0, 0, 1, 0, 0, 0, 0, 0, 8'h81); step(2);
    cfg(0, 0, 1, 31, 0, 0, 0, 0, 8'hFF); step(2);
    phase = "R12"; cfg(0, 0, 1, 31, 0, 1, 1, 0, 8'hFF);
    sw_rst(1); step(3);
    cfg(0, 0, 1, 31, 0, 1, 0, 1, 8'hFF); pulse_lock();
    phase = "R10"; cfg(0, 0, 0, 2, 1, 0, 0, 0, 8'h5A);
    st_los = 1; step(1); st_los = 0; step(1); pulse_lock();
    st_rate_lsb = 0; step(3);
    st_los = 1; step(1); st_los = 0; step(2);
    pulse_lock();
    step(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule